// File: doc/BRIEF.md
# Video Container Frame Assembler

This block sits on the transmit side of a Fibre-Channel-based avionics video link. It turns one video image into a sequence of payload frames. A vertical sync event opens a new image. The first frame of that image carries the container header words, then the ancillary words, and no pixels. Every horizontal sync event that follows opens one line frame, and that frame carries exactly one line of pixel words read from a line buffer.

Header and ancillary words are fetched through a combinational register read port: a section select plus a word index. Pixel words are fetched through a combinational line-buffer read port addressed by word index. Words leave over a valid/ready handshake, and a flag marks the last word of each frame. A downstream delimiter stage is told when to open a frame and which start-delimiter flavour to use: initiate for the first frame of an image, normal for the line frames. After the last word it is asked to close the frame, and the block waits for its acknowledge. The three lengths (header words, ancillary words, pixel words per line) are captured at vertical sync and held for the whole image.

Top module: `vid_frame_asm`

## Requirements
- R1: After synchronous active-low reset the block is idle: `out_valid`, `out_last`, `sof_strobe` and `eof_req` are 0, and `overrun` is 0.
- R2: A `vsync` pulse seen while idle raises `sof_strobe` for exactly one cycle, starting on the next cycle, with `sof_init`=1. A `hsync` pulse seen while idle, after at least one image has been opened, does the same with `sof_init`=0. A `hsync` before any `vsync` is ignored.
- R3: `cfg_hdr_words`, `cfg_anc_words` and `cfg_line_words` are sampled only when a `vsync` is accepted. Changes to them at any other time have no effect until the next accepted `vsync`.
- R4: The first frame presents the header words in order, with `reg_sel`=0 and index 0 to H-1. It then presents the ancillary words, with `reg_sel`=1 and index 0 to A-1. It carries no pixel word. A section of length 0 is skipped.
- R5: A line frame presents exactly P pixel words, read in order from line-buffer addresses 0 to P-1.
- R6: `out_last` is 1 on the final word of a frame only. A frame whose total length is 0 presents no words and goes straight from the start strobe to the close request.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` stays unchanged. A word advances only on a cycle where valid and ready are both 1.
- R8: `eof_req` rises on the cycle after the handshake of the last word, or on the cycle after the start strobe for an empty frame. It holds until `eof_ack` is seen, and the block is idle on the following cycle.
- R9: A `vsync` or `hsync` arriving while a frame is in progress is otherwise ignored and sets `overrun`. `overrun` stays 1 until reset.
- R10: A `vsync` and a `hsync` arriving together while idle open a new image (`sof_init`=1). The `hsync` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync | input | 1 | Single-cycle pulse that opens a new image |
| hsync | input | 1 | Single-cycle pulse that opens the next line frame |
| cfg_hdr_words | input | CNT_W | Container header length in words |
| cfg_anc_words | input | CNT_W | Ancillary data length in words |
| cfg_line_words | input | CNT_W | Pixel words per line |
| reg_sel | output | 1 | Register read section: 0 header, 1 ancillary |
| reg_idx | output | CNT_W | Register read word index |
| reg_data | input | DATA_W | Register read data (combinational) |
| pix_addr | output | CNT_W | Line-buffer read address |
| pix_data | input | DATA_W | Line-buffer read data (combinational) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final word of the frame |
| sof_strobe | output | 1 | One-cycle request to insert a start delimiter |
| sof_init | output | 1 | Start delimiter flavour: 1 initiate, 0 normal |
| eof_req | output | 1 | Request to insert the end delimiter |
| eof_ack | input | 1 | Delimiter stage has taken the end request |
| overrun | output | 1 | Sticky: a sync event arrived during a frame |

## Verification
Each sync event accepted at a clock edge shows up as `sof_strobe` one register later. The first data word is valid on the cycle after that. A word accepted by handshake is replaced by the next word on the following cycle, and `eof_req` appears one cycle after the last handshake. The bench drives inputs shortly after each rising edge and runs a behavioural model that advances on the same edge. It compares every output at the falling edge, so the result due after each stimulus is checked in exactly the cycle where it should appear. Back-pressure from a pseudo-random ready pattern and a delayed end-delimiter acknowledge stretch these windows, and the model follows them cycle by cycle.

// File: rtl/vfa_pkg.sv
// Shared types for the video container frame assembler.
package vfa_pkg;
    // Frame sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SOF  = 3'd1,
        ST_HDR  = 3'd2,
        ST_ANC  = 3'd3,
        ST_PAY  = 3'd4,
        ST_EOF  = 3'd5
    } vfa_state_t;
endpackage

// File: rtl/vfa_cfg_latch.sv
// Captures the three frame lengths when an image opens.
// Assumes load is a single-cycle strobe from the sequencer.
module vfa_cfg_latch #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] hdr_in,
    input  logic [CNT_W-1:0] anc_in,
    input  logic [CNT_W-1:0] pix_in,
    output logic [CNT_W-1:0] hdr_q,
    output logic [CNT_W-1:0] anc_q,
    output logic [CNT_W-1:0] pix_q
);
    // Hold the lengths for the whole image; update only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            anc_q <= '0;
            pix_q <= '0;
        end else if (load) begin
            hdr_q <= hdr_in;
            anc_q <= anc_in;
            pix_q <= pix_in;
        end
    end
endmodule

// File: rtl/vfa_word_ctr.sv
// Word index within the current section, with an end-of-section flag.
// Assumes limit is non-zero whenever inc or clr is used.
module vfa_word_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] idx,
    output logic             at_end
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] idx_plus;

    // Compare the next index against the section length.
    always_comb begin
        idx_plus = {1'b0, idx} + EXT_W'(1);
        at_end   = (idx_plus == {1'b0, limit});
    end

    // Advance on an accepted word; return to zero at the section end.
    always_ff @(posedge clk) begin
        if (!rst_n)   idx <= '0;
        else if (clr) idx <= '0;
        else if (inc) idx <= idx + CNT_W'(1);
    end
endmodule

// File: rtl/vfa_fsm.sv
// Frame sequencer: reacts to sync events, walks header, ancillary and
// pixel sections, drives start/end delimiter requests and the sticky
// overrun flag. Assumes vsync/hsync are single-cycle pulses.
module vfa_fsm
    import vfa_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync,
    input  logic             hsync,
    input  logic             out_ready,
    input  logic             eof_ack,
    input  logic [CNT_W-1:0] hdr_n,
    input  logic [CNT_W-1:0] anc_n,
    input  logic [CNT_W-1:0] pix_n,
    input  logic             at_end,
    output vfa_state_t       state,
    output logic [CNT_W-1:0] sec_len,
    output logic             ctr_inc,
    output logic             ctr_clr,
    output logic             load_cfg,
    output logic             first_q,
    output logic             overrun,
    output logic             out_valid,
    output logic             out_last,
    output logic             sof_strobe,
    output logic             eof_req
);
    vfa_state_t state_nx;
    logic       active_q;
    logic       hs;
    logic       take_v;
    logic       take_h;
    logic       hdr_zero;
    logic       anc_zero;
    logic       pix_zero;

    // Decode section flags and handshake.
    always_comb begin
        hdr_zero   = (hdr_n == '0);
        anc_zero   = (anc_n == '0);
        pix_zero   = (pix_n == '0);
        out_valid  = (state == ST_HDR) || (state == ST_ANC) || (state == ST_PAY);
        hs         = out_valid && out_ready;
        ctr_inc    = hs && !at_end;
        ctr_clr    = hs && at_end;
        take_v     = (state == ST_IDLE) && vsync;
        take_h     = (state == ST_IDLE) && !vsync && hsync && active_q;
        load_cfg   = take_v;
        sof_strobe = (state == ST_SOF);
        eof_req    = (state == ST_EOF);
        out_last   = out_valid && at_end &&
                     ((state != ST_HDR) || anc_zero);
    end

    // Pick the length of the section being sent.
    always_comb begin
        unique case (state)
            ST_HDR:  sec_len = hdr_n;
            ST_ANC:  sec_len = anc_n;
            default: sec_len = pix_n;
        endcase
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (take_v || take_h) state_nx = ST_SOF;
            ST_SOF: begin
                if (first_q) begin
                    if (!hdr_zero)      state_nx = ST_HDR;
                    else if (!anc_zero) state_nx = ST_ANC;
                    else                state_nx = ST_EOF;
                end else begin
                    state_nx = pix_zero ? ST_EOF : ST_PAY;
                end
            end
            ST_HDR:  if (ctr_clr) state_nx = anc_zero ? ST_EOF : ST_ANC;
            ST_ANC:  if (ctr_clr) state_nx = ST_EOF;
            ST_PAY:  if (ctr_clr) state_nx = ST_EOF;
            ST_EOF:  if (eof_ack) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Track whether an image is open and whether this frame is its first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            first_q  <= 1'b0;
        end else if (take_v) begin
            active_q <= 1'b1;
            first_q  <= 1'b1;
        end else if (take_h) begin
            first_q  <= 1'b0;
        end
    end

    // Sticky flag for sync events that land inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else if ((state != ST_IDLE) && (vsync || hsync)) overrun <= 1'b1;
    end

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sof_strobe |=> !sof_strobe); // R2
    AST_EOF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_req && !eof_ack) |=> eof_req); // R8
    AST_EOF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_req && eof_ack) |=> !out_valid && !sof_strobe && !eof_req); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R9
    AST_LAST_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R6
    AST_LAST_TO_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |=> eof_req); // R8
endmodule

// File: rtl/vid_frame_asm.sv
// Video container frame assembler top: ties the sequencer, the length
// latch and the word counter together and selects the output word.
// Assumes register and line-buffer reads return data in the same cycle.
module vid_frame_asm
    import vfa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              hsync,
    input  logic [CNT_W-1:0]  cfg_hdr_words,
    input  logic [CNT_W-1:0]  cfg_anc_words,
    input  logic [CNT_W-1:0]  cfg_line_words,
    output logic              reg_sel,
    output logic [CNT_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_data,
    output logic [CNT_W-1:0]  pix_addr,
    input  logic [DATA_W-1:0] pix_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              sof_strobe,
    output logic              sof_init,
    output logic              eof_req,
    input  logic              eof_ack,
    output logic              overrun
);
    vfa_state_t       st;
    logic [CNT_W-1:0] hdr_q, anc_q, pix_q;
    logic [CNT_W-1:0] sec_len;
    logic [CNT_W-1:0] idx;
    logic             at_end, ctr_inc, ctr_clr, load_cfg, first_q;

    vfa_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load_cfg),
        .hdr_in(cfg_hdr_words), .anc_in(cfg_anc_words), .pix_in(cfg_line_words),
        .hdr_q(hdr_q), .anc_q(anc_q), .pix_q(pix_q)
    );

    vfa_word_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .inc(ctr_inc),
        .limit(sec_len), .idx(idx), .at_end(at_end)
    );

    vfa_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
        .out_ready(out_ready), .eof_ack(eof_ack),
        .hdr_n(hdr_q), .anc_n(anc_q), .pix_n(pix_q), .at_end(at_end),
        .state(st), .sec_len(sec_len), .ctr_inc(ctr_inc), .ctr_clr(ctr_clr),
        .load_cfg(load_cfg), .first_q(first_q), .overrun(overrun),
        .out_valid(out_valid), .out_last(out_last),
        .sof_strobe(sof_strobe), .eof_req(eof_req)
    );

    // Route the word index to both read ports and select the output word.
    always_comb begin
        reg_sel  = (st == ST_ANC);
        reg_idx  = idx;
        pix_addr = idx;
        sof_init = first_q;
        out_data = (st == ST_PAY) ? pix_data : reg_data;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(hdr_q) && $stable(anc_q) && $stable(pix_q)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(reg_idx)
            && $stable(reg_sel) && $stable(pix_addr)); // R7
    AST_NO_PIX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && first_q) |-> (st != ST_PAY)); // R4
endmodule

// File: tb/vid_frame_asm_test.sv
// Bench: behavioural cycle model, compared on every falling edge.
module vid_frame_asm_test;
    localparam int DW = 32;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync = 1'b0, hsync = 1'b0, out_ready = 1'b1, eof_ack = 1'b0;
    logic [CW-1:0] cfg_h = '0, cfg_a = '0, cfg_p = '0;
    logic reg_sel, out_valid, out_last, sof_strobe, sof_init, eof_req, overrun;
    logic [CW-1:0] reg_idx, pix_addr;
    logic [DW-1:0] reg_data, pix_data, out_data;

    int compared = 0, mismatched = 0, cyc = 0;
    bit rnd_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int ack_wait = 0;

    always #2.5 clk = ~clk;

    // Register file and line buffer contents, computed from the address.
    assign reg_data = {reg_sel ? 16'hB0B0 : 16'hA0A0, 4'h0, reg_idx};
    assign pix_data = {16'hC0DE, 4'h0, pix_addr};

    vid_frame_asm #(.DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
        .cfg_hdr_words(cfg_h), .cfg_anc_words(cfg_a), .cfg_line_words(cfg_p),
        .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_data(reg_data),
        .pix_addr(pix_addr), .pix_data(pix_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .sof_strobe(sof_strobe), .sof_init(sof_init),
        .eof_req(eof_req), .eof_ack(eof_ack), .overrun(overrun)
    );

    // Reference model: 0 idle, 1 start, 2 header, 3 ancillary, 4 pixels, 5 close.
    int ms = 0, mc = 0, mh = 0, ma = 0, mp = 0;
    bit mact = 0, mfirst = 0, movr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mc = 0; mh = 0; ma = 0; mp = 0; mact = 0; mfirst = 0; movr = 0;
        end else begin
            if (ms != 0 && (vsync || hsync)) movr = 1;            // R9
            case (ms)
                0: if (vsync) begin                               // R10: vsync wins
                       mh = cfg_h; ma = cfg_a; mp = cfg_p;        // R3
                       mact = 1; mfirst = 1; ms = 1;
                   end else if (hsync && mact) begin
                       mfirst = 0; ms = 1;
                   end
                1: if (mfirst) ms = (mh > 0) ? 2 : ((ma > 0) ? 3 : 5);
                   else        ms = (mp > 0) ? 4 : 5;
                2: if (out_ready) begin
                       mc++;
                       if (mc == mh) begin mc = 0; ms = (ma > 0) ? 3 : 5; end
                   end
                3: if (out_ready) begin mc++; if (mc == ma) begin mc = 0; ms = 5; end end
                4: if (out_ready) begin mc++; if (mc == mp) begin mc = 0; ms = 5; end end
                5: if (eof_ack) ms = 0;
                default: ms = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic ev, el;
            logic [DW-1:0] ed;
            cyc++;
            ev = (ms >= 2 && ms <= 4);
            ed = (ms == 2) ? {16'hA0A0, 4'h0, CW'(mc)} :
                 (ms == 3) ? {16'hB0B0, 4'h0, CW'(mc)} :
                 (ms == 4) ? {16'hC0DE, 4'h0, CW'(mc)} : '0;
            el = ev && ((ms == 2 && mc == mh - 1 && ma == 0) ||
                        (ms == 3 && mc == ma - 1) || (ms == 4 && mc == mp - 1));
            chk("R7 out_valid", DW'(out_valid), DW'(ev));
            if (ev) chk("R4 R5 R7 out_data", out_data, ed);
            chk("R6 out_last", DW'(out_last), DW'(el));
            chk("R2 sof_strobe", DW'(sof_strobe), DW'(ms == 1));
            if (ms == 1) chk("R2 R10 sof_init", DW'(sof_init), DW'(mfirst));
            chk("R8 eof_req", DW'(eof_req), DW'(ms == 5));
            chk("R9 overrun", DW'(overrun), DW'(movr));
        end
    end

    // Downstream responders: pseudo-random ready and delayed close acknowledge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = rnd_ready ? lfsr[0] : 1'b1;
        if (eof_req) begin
            ack_wait++;
            eof_ack = (ack_wait >= 3);
        end else begin
            ack_wait = 0;
            eof_ack = 1'b0;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input bit v, input bit h);
        vsync = v; hsync = h;
        step(1);
        vsync = 1'b0; hsync = 1'b0;
    endtask

    initial begin
        step(3);
        @(negedge clk);
        chk("R1 out_valid", DW'(out_valid), 0);
        chk("R1 sof_strobe", DW'(sof_strobe), 0);
        chk("R1 eof_req", DW'(eof_req), 0);
        chk("R1 overrun", DW'(overrun), 0);
        chk("R1 out_last", DW'(out_last), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(2);
        pulse(0, 1);                 // R2: hsync before any image is ignored
        step(3);
        cfg_h = 12'd3; cfg_a = 12'd2; cfg_p = 12'd5;
        pulse(1, 0);                 // R2 R4: first frame
        cfg_h = 12'd7; cfg_a = 12'd7; cfg_p = 12'd7;   // R3: late change ignored
        step(20);
        pulse(0, 1);                 // R5: line frame of 5 words
        step(20);
        rnd_ready = 1'b1;            // R7: back-pressure
        pulse(0, 1);
        step(2);
        pulse(0, 1);                 // R9: hsync mid-frame
        step(30);
        pulse(0, 1);
        step(30);
        rnd_ready = 1'b0;
        cfg_h = 12'd2; cfg_a = 12'd0; cfg_p = 12'd0;
        pulse(1, 0);                 // R4: empty ancillary section skipped
        step(15);
        pulse(0, 1);                 // R6: empty line frame
        step(15);
        cfg_h = 12'd0; cfg_a = 12'd0; cfg_p = 12'd1;
        pulse(1, 0);                 // R6 R8: empty first frame
        step(15);
        pulse(0, 1);
        step(15);
        cfg_h = 12'd0; cfg_a = 12'd4; cfg_p = 12'd3;
        pulse(1, 1);                 // R10: both together, vsync wins
        step(25);
        rnd_ready = 1'b1;
        pulse(0, 1);
        step(40);
        pulse(1, 0);                 // R9: vsync outside a frame is fine; stays sticky
        step(40);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule